// File: doc/BRIEF.md
# Hub Downstream Port Power Controller

This block owns the power enables of the downstream ports of a small hub with two or three ports. The hub command logic sends it per-port requests to apply or remove power. Overcurrent indications arrive from the external power switches as active-low levels. Each indication is filtered against short spikes before it is acted on. A qualified fault removes power from the affected port, and from every port when the block runs in ganged mode. The port then stays unpowered until the fault has gone and the host asks for power again.

The filtered fault level of each port is reported upward as a status flag. A sticky change flag records every transition of that status until the hub logic clears it. A mode input selects ganged or individual power and fault handling. A second mode input reduces the hub to two ports, which takes the highest-numbered port out of service. A prescaler on the core clock produces the sample strobe for the filter, nominally one strobe every 2 ms.

Top module: `hub_port_power`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, every `pwr_en_n_o` bit is 1 (power off) and every `oc_stat_o` and `oc_chg_o` bit is 0.
- R2: In individual mode, a one-cycle pulse on `pwr_on_req_i[i]` drives `pwr_en_n_o[i]` low from the next clock edge, and a pulse on `pwr_off_req_i[i]` drives it high. When both requests arrive in the same cycle, the port is turned off.
- R3: Each port's overcurrent input is sampled once every `TICK_CYCLES` clocks. `oc_stat_o[i]` goes to 1 only after two consecutive samples see `oc_n_i[i]` low. A low pulse that covers a single sample changes neither status nor power.
- R4: A fault is released only after two consecutive samples see the input high. A single high sample during a fault leaves `oc_stat_o[i]` at 1.
- R5: In individual mode (`gang_mode_i` = 0), a qualified fault on port i sets only `oc_stat_o[i]` and turns off only `pwr_en_n_o[i]`.
- R6: In ganged mode (`gang_mode_i` = 1), a power-on request on any in-service port powers every in-service port. A power-off request on any of them turns all of them off. A qualified fault on any of them sets the status of all of them and turns all of them off.
- R7: When `two_port_i` = 1, the highest-numbered port is out of service. Its overcurrent input is ignored, its status reads 0, its power enable stays high, and requests for it have no effect.
- R8: While a port's status is 1, power-on requests for that port are ignored. After the fault clears, the port stays off until a new power-on request arrives.
- R9: `oc_chg_o[i]` is set on the clock edge after any change of `oc_stat_o[i]`, in either direction. It holds until a pulse on `oc_chg_clr_i[i]` clears it. A new change in the same cycle as the clear takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| gang_mode_i | input | 1 | 1 = ganged power and fault handling, 0 = individual |
| two_port_i | input | 1 | 1 = highest-numbered port out of service |
| oc_n_i | input | NPORTS | Overcurrent indications, active low |
| pwr_on_req_i | input | NPORTS | Power-on request pulses per port |
| pwr_off_req_i | input | NPORTS | Power-off request pulses per port |
| oc_chg_clr_i | input | NPORTS | Clear pulses for the change flags |
| pwr_en_n_o | output | NPORTS | Power enables, active low, push-pull |
| oc_stat_o | output | NPORTS | Filtered overcurrent status per port |
| oc_chg_o | output | NPORTS | Sticky status-change flags |

## Verification
The assertions check the rules that relate one cycle to the next. The reset state is one of them. Power may only turn on after a request, and a reported fault must remove power on the following edge. In individual mode an off request beats an on request. In ganged mode a clean on request powers every port. The reduced port stays dead. Change flags only rise after a status transition and only fall after a clear.

The spike filter depends on where the input edges fall relative to the sample strobe, and the checker cannot see those strobes, so only the bench scenarios show it. A single-sample glitch is ignored in both directions. A port stays off after its fault clears until the host asks again. The complete sequences that mix ganged, individual and two-port modes are also bench-only.

// File: rtl/hpp_pkg.sv
package hpp_pkg;

    typedef enum logic {
        SCHEME_PER_PORT = 1'b0,
        SCHEME_GANGED   = 1'b1
    } pwr_scheme_e;

    // Spike filter state for one port: the previous raw sample and the
    // level that has been accepted after two agreeing samples.
    typedef struct packed {
        logic last_smp;
        logic qual;
    } oc_flt_t;

    // Resolved per-port control after the ganged/individual selection.
    typedef struct packed {
        logic live;
        logic fault;
        logic off;
        logic on;
    } port_ctl_t;

    function automatic oc_flt_t flt_step(input oc_flt_t cur, input logic smp);
        oc_flt_t nxt;
        nxt.last_smp = smp;
        nxt.qual     = (smp == cur.last_smp) ? smp : cur.qual;
        return nxt;
    endfunction

    // Priority: out of service, then fault, then off request, then on request.
    function automatic logic pwr_step(input port_ctl_t c, input logic cur);
        logic nxt;
        if (!c.live)      nxt = 1'b0;
        else if (c.fault) nxt = 1'b0;
        else if (c.off)   nxt = 1'b0;
        else if (c.on)    nxt = 1'b1;
        else              nxt = cur;
        return nxt;
    endfunction

    // A new status transition wins over a clear in the same cycle.
    function automatic logic chg_step(input logic differ, input logic clr, input logic cur);
        logic nxt;
        if (differ)   nxt = 1'b1;
        else if (clr) nxt = 1'b0;
        else          nxt = cur;
        return nxt;
    endfunction

endpackage

// File: rtl/hpp_tick_gen.sv
module hpp_tick_gen #(
    parameter int unsigned TICK_CYCLES = 96000
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int unsigned CW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
    end

    assign tick_o = (cnt_q == LAST);

endmodule

// File: rtl/hpp_oc_filter.sv
module hpp_oc_filter
    import hpp_pkg::*;
#(
    parameter int unsigned NPORTS = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic [NPORTS-1:0] smp_i,
    output logic [NPORTS-1:0] qual_o
);
    for (genvar gi = 0; gi < NPORTS; gi++) begin : g_port
        oc_flt_t st_q;

        always_ff @(posedge clk) begin
            if (rst)         st_q <= '0;
            else if (tick_i) st_q <= flt_step(st_q, smp_i[gi]);
        end

        assign qual_o[gi] = st_q.qual;
    end

endmodule

// File: rtl/hpp_pwr_ctrl.sv
module hpp_pwr_ctrl
    import hpp_pkg::*;
#(
    parameter int unsigned NPORTS = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  pwr_scheme_e       scheme_i,
    input  logic [NPORTS-1:0] live_i,
    input  logic [NPORTS-1:0] qual_i,
    input  logic [NPORTS-1:0] on_req_i,
    input  logic [NPORTS-1:0] off_req_i,
    input  logic [NPORTS-1:0] chg_clr_i,
    output logic [NPORTS-1:0] pwr_on_o,
    output logic [NPORTS-1:0] fault_o,
    output logic [NPORTS-1:0] chg_o
);
    logic any_fault;
    logic any_on;
    logic any_off;
    logic ganged;

    assign ganged    = (scheme_i == SCHEME_GANGED);
    assign any_fault = |(qual_i & live_i);
    assign any_on    = |(on_req_i & live_i);
    assign any_off   = |(off_req_i & live_i);

    for (genvar gi = 0; gi < NPORTS; gi++) begin : g_port
        port_ctl_t ctl;
        logic      pwr_q;
        logic      stat_q;
        logic      chg_q;
        logic      fault_now;

        assign ctl.live  = live_i[gi];
        assign ctl.fault = ganged ? any_fault : qual_i[gi];
        assign ctl.off   = ganged ? any_off   : off_req_i[gi];
        assign ctl.on    = ganged ? any_on    : on_req_i[gi];

        assign fault_now = ctl.live & ctl.fault;

        always_ff @(posedge clk) begin
            if (rst) begin
                pwr_q  <= 1'b0;
                stat_q <= 1'b0;
                chg_q  <= 1'b0;
            end else begin
                pwr_q  <= pwr_step(ctl, pwr_q);
                stat_q <= fault_now;
                chg_q  <= chg_step(fault_now != stat_q, chg_clr_i[gi], chg_q);
            end
        end

        assign pwr_on_o[gi] = pwr_q;
        assign fault_o[gi]  = fault_now;
        assign chg_o[gi]    = chg_q;
    end

endmodule

// File: rtl/hub_port_power.sv
module hub_port_power
    import hpp_pkg::*;
#(
    parameter int unsigned NPORTS      = 3,
    parameter int unsigned TICK_CYCLES = 96000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              gang_mode_i,
    input  logic              two_port_i,
    input  logic [NPORTS-1:0] oc_n_i,
    input  logic [NPORTS-1:0] pwr_on_req_i,
    input  logic [NPORTS-1:0] pwr_off_req_i,
    input  logic [NPORTS-1:0] oc_chg_clr_i,
    output logic [NPORTS-1:0] pwr_en_n_o,
    output logic [NPORTS-1:0] oc_stat_o,
    output logic [NPORTS-1:0] oc_chg_o
);
    localparam logic [NPORTS-1:0] TOP_BIT = {1'b1, {(NPORTS-1){1'b0}}};

    logic              tick;
    logic [NPORTS-1:0] live;
    logic [NPORTS-1:0] smp;
    logic [NPORTS-1:0] qual;
    logic [NPORTS-1:0] pwr_on;
    pwr_scheme_e       scheme;

    assign live   = two_port_i ? ~TOP_BIT : {NPORTS{1'b1}};
    assign smp    = ~oc_n_i & live;
    assign scheme = gang_mode_i ? SCHEME_GANGED : SCHEME_PER_PORT;

    hpp_tick_gen #(
        .TICK_CYCLES(TICK_CYCLES)
    ) u_tick (
        .clk    (clk),
        .rst    (rst),
        .tick_o (tick)
    );

    hpp_oc_filter #(
        .NPORTS(NPORTS)
    ) u_filter (
        .clk    (clk),
        .rst    (rst),
        .tick_i (tick),
        .smp_i  (smp),
        .qual_o (qual)
    );

    hpp_pwr_ctrl #(
        .NPORTS(NPORTS)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .scheme_i  (scheme),
        .live_i    (live),
        .qual_i    (qual),
        .on_req_i  (pwr_on_req_i),
        .off_req_i (pwr_off_req_i),
        .chg_clr_i (oc_chg_clr_i),
        .pwr_on_o  (pwr_on),
        .fault_o   (oc_stat_o),
        .chg_o     (oc_chg_o)
    );

    assign pwr_en_n_o = ~pwr_on;

endmodule

// File: rtl/hub_port_power_chk.sv
module hub_port_power_chk #(
    parameter int unsigned NPORTS = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              gang_mode_i,
    input logic              two_port_i,
    input logic [NPORTS-1:0] pwr_on_req_i,
    input logic [NPORTS-1:0] pwr_off_req_i,
    input logic [NPORTS-1:0] oc_chg_clr_i,
    input logic [NPORTS-1:0] pwr_en_n_o,
    input logic [NPORTS-1:0] oc_stat_o,
    input logic [NPORTS-1:0] oc_chg_o
);
    logic rst_q;

    always_ff @(posedge clk) rst_q <= rst;

    // R1: state right after a reset edge
    always @(negedge clk) begin
        if (rst_q) begin
            a_r1_reset_state: assert (pwr_en_n_o == '1 && oc_stat_o == '0 && oc_chg_o == '0)
                else $error("reset state wrong");
        end
    end

    // R6: a clean ganged power-on request powers every port
    a_r6_gang_on_all: assert property (@(posedge clk) disable iff (rst)
        (gang_mode_i && !two_port_i && (|pwr_on_req_i) && !(|pwr_off_req_i) && !(|oc_stat_o))
        |=> (pwr_en_n_o == '0));

    // R7: the reduced port stays dead
    a_r7_top_port_dead: assert property (@(posedge clk) disable iff (rst)
        (two_port_i && $past(two_port_i)) |-> (pwr_en_n_o[NPORTS-1] && !oc_stat_o[NPORTS-1]));

    for (genvar gi = 0; gi < NPORTS; gi++) begin : g_port
        // R2: power only turns on after some request
        a_r2_on_after_req: assert property (@(posedge clk) disable iff (rst)
            $fell(pwr_en_n_o[gi]) |-> $past(|pwr_on_req_i));

        // R2: off request wins in individual mode
        a_r2_off_wins: assert property (@(posedge clk) disable iff (rst)
            (!gang_mode_i && pwr_off_req_i[gi]) |=> pwr_en_n_o[gi]);

        // R8: a reported fault removes power on the next edge
        a_r8_fault_cuts_power: assert property (@(posedge clk) disable iff (rst)
            oc_stat_o[gi] |=> pwr_en_n_o[gi]);

        // R9: flag rises only after a status transition
        a_r9_chg_rise: assert property (@(posedge clk) disable iff (rst)
            $rose(oc_chg_o[gi]) |-> ($past(oc_stat_o[gi]) != $past(oc_stat_o[gi], 2)));

        // R9: flag falls only after a clear pulse
        a_r9_chg_fall: assert property (@(posedge clk) disable iff (rst)
            $fell(oc_chg_o[gi]) |-> $past(oc_chg_clr_i[gi]));
    end

endmodule

bind hub_port_power hub_port_power_chk #(
    .NPORTS(NPORTS)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .gang_mode_i   (gang_mode_i),
    .two_port_i    (two_port_i),
    .pwr_on_req_i  (pwr_on_req_i),
    .pwr_off_req_i (pwr_off_req_i),
    .oc_chg_clr_i  (oc_chg_clr_i),
    .pwr_en_n_o    (pwr_en_n_o),
    .oc_stat_o     (oc_stat_o),
    .oc_chg_o      (oc_chg_o)
);

// File: tb/hub_port_power_bench.sv
`timescale 1ns/100ps
module hub_port_power_bench;
    localparam int NP     = 3;
    localparam int TK     = 4;
    localparam int SETTLE = 3 * TK + 4;
    localparam int NV     = 15;

    typedef struct packed {
        logic       gang;
        logic       two;
        logic [2:0] ocn;
        logic [2:0] on;
        logic [2:0] off;
        logic [2:0] epn;
        logic [2:0] est;
        logic [3:0] rq;
    } vec_t;

    // gang two  ocn     on      off     exp_pwr_n exp_stat req
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 3'b111, 3'b111, 3'b000, 3'b000, 3'b000, 4'd2},  // R2 all on
        '{1'b0, 1'b0, 3'b110, 3'b000, 3'b000, 3'b001, 3'b001, 4'd5},  // R5 port0 trips alone
        '{1'b0, 1'b0, 3'b111, 3'b000, 3'b000, 3'b001, 3'b000, 4'd8},  // R8 stays off
        '{1'b0, 1'b0, 3'b111, 3'b001, 3'b000, 3'b000, 3'b000, 4'd8},  // R8 new request
        '{1'b0, 1'b0, 3'b111, 3'b000, 3'b010, 3'b010, 3'b000, 4'd2},  // R2 off port1
        '{1'b1, 1'b0, 3'b111, 3'b010, 3'b000, 3'b000, 3'b000, 4'd6},  // R6 one request, all on
        '{1'b1, 1'b0, 3'b011, 3'b000, 3'b000, 3'b111, 3'b111, 4'd6},  // R6 one fault, all off
        '{1'b1, 1'b0, 3'b011, 3'b111, 3'b000, 3'b111, 3'b111, 4'd8},  // R8 request during fault
        '{1'b1, 1'b0, 3'b111, 3'b000, 3'b000, 3'b111, 3'b000, 4'd8},  // R8 cleared, still off
        '{1'b1, 1'b1, 3'b111, 3'b001, 3'b000, 3'b100, 3'b000, 4'd7},  // R7 gang excludes top
        '{1'b1, 1'b1, 3'b011, 3'b000, 3'b000, 3'b100, 3'b000, 4'd7},  // R7 top fault ignored
        '{1'b0, 1'b1, 3'b011, 3'b100, 3'b000, 3'b100, 3'b000, 4'd7},  // R7 top request ignored
        '{1'b0, 1'b0, 3'b111, 3'b000, 3'b111, 3'b111, 3'b000, 4'd2},  // R2 all off
        '{1'b0, 1'b0, 3'b101, 3'b111, 3'b000, 3'b010, 3'b010, 4'd5},  // R5 port1 trips alone
        '{1'b0, 1'b0, 3'b111, 3'b000, 3'b000, 3'b010, 3'b000, 4'd4}   // R4 release
    };

    logic          clk = 1'b0;
    logic          rst;
    logic          gang_mode_i;
    logic          two_port_i;
    logic [NP-1:0] oc_n_i;
    logic [NP-1:0] pwr_on_req_i;
    logic [NP-1:0] pwr_off_req_i;
    logic [NP-1:0] oc_chg_clr_i;
    logic [NP-1:0] pwr_en_n_o;
    logic [NP-1:0] oc_stat_o;
    logic [NP-1:0] oc_chg_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    hub_port_power #(
        .NPORTS      (NP),
        .TICK_CYCLES (TK)
    ) u_hub_port_power (
        .clk           (clk),
        .rst           (rst),
        .gang_mode_i   (gang_mode_i),
        .two_port_i    (two_port_i),
        .oc_n_i        (oc_n_i),
        .pwr_on_req_i  (pwr_on_req_i),
        .pwr_off_req_i (pwr_off_req_i),
        .oc_chg_clr_i  (oc_chg_clr_i),
        .pwr_en_n_o    (pwr_en_n_o),
        .oc_stat_o     (oc_stat_o),
        .oc_chg_o      (oc_chg_o)
    );

    task automatic chk(input string rq, input string what,
                       input logic [NP-1:0] act, input logic [NP-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", rq, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input logic [NP-1:0] on, input logic [NP-1:0] off,
                         input logic [NP-1:0] clr);
        pwr_on_req_i  = on;
        pwr_off_req_i = off;
        oc_chg_clr_i  = clr;
        @(negedge clk);
        pwr_on_req_i  = '0;
        pwr_off_req_i = '0;
        oc_chg_clr_i  = '0;
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog (all R): actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        logic ok;
        rst           = 1'b1;
        gang_mode_i   = 1'b0;
        two_port_i    = 1'b0;
        oc_n_i        = '1;
        pwr_on_req_i  = '0;
        pwr_off_req_i = '0;
        oc_chg_clr_i  = '0;
        step(3);
        chk("R1", "pwr_en_n in reset", pwr_en_n_o, 3'b111);
        chk("R1", "stat in reset", oc_stat_o, 3'b000);
        chk("R1", "chg in reset", oc_chg_o, 3'b000);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "pwr_en_n after reset", pwr_en_n_o, 3'b111);

        // Table walk
        for (int k = 0; k < NV; k++) begin
            gang_mode_i = VECS[k].gang;
            two_port_i  = VECS[k].two;
            oc_n_i      = VECS[k].ocn;
            pulse(VECS[k].on, VECS[k].off, 3'b000);
            step(SETTLE);
            chk($sformatf("R%0d", VECS[k].rq), $sformatf("vec %0d pwr_en_n", k),
                pwr_en_n_o, VECS[k].epn);
            chk($sformatf("R%0d", VECS[k].rq), $sformatf("vec %0d stat", k),
                oc_stat_o, VECS[k].est);
        end

        // R2: one-cycle latency and off-wins
        pulse(3'b111, 3'b000, 3'b000);
        chk("R2", "on next edge", pwr_en_n_o, 3'b000);
        pulse(3'b001, 3'b001, 3'b000);
        chk("R2", "off beats on", pwr_en_n_o, 3'b001);
        pulse(3'b001, 3'b000, 3'b000);
        chk("R2", "port0 back on", pwr_en_n_o, 3'b000);

        // R3: single-sample spike is ignored
        ok = 1'b1;
        oc_n_i = 3'b110;
        for (int k = 0; k < 4 * TK; k++) begin
            if (k == TK) oc_n_i = 3'b111;
            @(negedge clk);
            if (oc_stat_o !== 3'b000 || pwr_en_n_o !== 3'b000) ok = 1'b0;
        end
        chk("R3", "spike left no trace", {2'b00, ok}, 3'b001);
        oc_n_i = 3'b110;
        step(SETTLE);
        chk("R3", "stat after steady fault", oc_stat_o, 3'b001);
        chk("R5", "power after steady fault", pwr_en_n_o, 3'b001);

        // R4: single high sample does not release
        ok = 1'b1;
        oc_n_i = 3'b111;
        for (int k = 0; k < 4 * TK; k++) begin
            if (k == TK) oc_n_i = 3'b110;
            @(negedge clk);
            if (oc_stat_o !== 3'b001) ok = 1'b0;
        end
        chk("R4", "fault held through gap", {2'b00, ok}, 3'b001);
        oc_n_i = 3'b111;
        step(SETTLE);
        chk("R4", "stat released", oc_stat_o, 3'b000);
        chk("R8", "port stays off", pwr_en_n_o, 3'b001);

        // R9: change flags
        pulse(3'b000, 3'b000, 3'b111);
        chk("R9", "flags cleared", oc_chg_o, 3'b000);
        pulse(3'b001, 3'b000, 3'b000);
        oc_n_i = 3'b110;
        step(SETTLE);
        chk("R9", "flag on rise", oc_chg_o, 3'b001);
        pulse(3'b000, 3'b000, 3'b001);
        chk("R9", "flag cleared", oc_chg_o, 3'b000);
        oc_n_i = 3'b111;
        step(SETTLE);
        chk("R9", "flag on fall", oc_chg_o, 3'b001);

        // R1: reset mid-run
        pulse(3'b110, 3'b000, 3'b000);
        rst = 1'b1;
        step(2);
        chk("R1", "pwr_en_n mid-run reset", pwr_en_n_o, 3'b111);
        chk("R1", "chg mid-run reset", oc_chg_o, 3'b000);
        rst = 1'b0;
        step(2);

        summary();
        $finish;
    end

endmodule